// File: doc/BRIEF.md
# Float to half-precision converter

This block narrows a binary32 or binary64 floating-point operand to a 16-bit half-precision value. The source format is picked per operand. Software-visible controls pick the rounding direction and turn on flush-to-zero of subnormal inputs and a canonical quiet NaN result. A further control selects an alternative half encoding that gives up infinities and NaNs in exchange for one more usable exponent value. The block also reports four sticky-style exception conditions alongside each result: invalid, overflow, underflow and inexact.

The conversion itself is a single combinational path. It unpacks and rebiases the source and sorts it into a value class. It then shifts tiny values right into the subnormal range while keeping a guard bit and a sticky bit, rounds, checks the half range, and packs the result. A parameter chooses whether the result and flags leave through a register or straight from the logic. With the default setting the result is registered, which suits a pipeline stage of a floating-point unit.

Top module: `fp2h_conv`

## Requirements
- R1: With OUT_REG=1 (default), the result and flags for the inputs present at a rising clock edge appear after that edge. While rst_n is low, every output is 0.
- R2: With src_is_dbl=1 the operand is binary64: sign at bit 63, exponent 62:52, fraction 51:0. With src_is_dbl=0 only bits 31:0 are read: sign at bit 31, exponent 30:23, fraction 22:0. Bits 63:32 then have no effect on any output.
- R3: A source of exponent 0 and fraction 0 gives {sign, 15'b0} with every flag clear.
- R4: In IEEE mode (alt_half_en=0) with dnan_en=0, a NaN gives {sign, 5'h1F, top ten fraction bits with bit 9 forced to 1}. Invalid is raised only if the top fraction bit is 0 (signalling).
- R5: With dnan_en=1 in IEEE mode, any NaN gives 16'h7E00. Invalid is raised only for a signalling NaN.
- R6: With alt_half_en=1, a NaN gives {sign, 15'b0} and an infinity gives {sign, 15'h7FFF}. Both raise invalid.
- R7: In IEEE mode, an infinity gives {sign, 15'h7C00} with no flags.
- R8: rnd_mode 2'b00 rounds to nearest, ties to even. It rounds up when the discarded part is above half an ulp, or exactly half with the kept LSB 1. A mantissa carry increments the exponent.
- R9: rnd_mode 2'b01 rounds toward +infinity, 2'b10 toward -infinity and 2'b11 toward zero. A directed mode rounds up in magnitude only when the sign matches its direction and the discarded part is nonzero.
- R10: Results below the half normal range become subnormal, with every shifted-out bit kept in the sticky bit. Underflow is raised when the result is tiny before rounding and either inexact is set or uf_trap_en=1.
- R11: In IEEE mode, a rounded exponent of 31 or more raises overflow and inexact. The result is infinity for nearest rounding and for a directed mode that points away from zero, and 15'h7BFF in magnitude otherwise.
- R12: With alt_half_en=1, exponent 31 is an ordinary finite value. A rounded exponent of 32 or more gives {sign, 15'h7FFF} with only invalid raised.
- R13: With ftz_en=1, a subnormal source gives {sign, 15'b0} with every flag clear.
- R14: Inexact is raised for a finite in-range result whenever any discarded bit is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| src_bits | input | 64 | Source operand bits |
| src_is_dbl | input | 1 | 1: binary64 source, 0: binary32 in bits 31:0 |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward +inf, 10 toward -inf, 11 toward zero |
| ftz_en | input | 1 | Flush subnormal sources to signed zero |
| dnan_en | input | 1 | Replace every NaN with the canonical quiet NaN |
| alt_half_en | input | 1 | Alternative half encoding without infinities or NaNs |
| uf_trap_en | input | 1 | Report underflow for every tiny result, exact or not |
| half_out | output | 16 | Half-precision result |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Result above the half range |
| flag_underflow | output | 1 | Tiny result |
| flag_inexact | output | 1 | Result differs from the exact value |

## Verification
The result and all four flags come from one register, so every output is due exactly one rising edge after its operand and controls. The bench changes inputs on a falling edge and compares the outputs at the following falling edge, half a period after the capturing edge. It never samples on the edge itself, so no comparison can catch a value in transition. The reset value is read while reset is still held, before any operand is applied.

// File: rtl/fp2h_pkg.sv
package fp2h_pkg;
   localparam int DBL_EW   = 11;
   localparam int DBL_MW   = 52;
   localparam int SGL_EW   = 8;
   localparam int SGL_MW   = 23;
   localparam int HLF_EW   = 5;
   localparam int HLF_MW   = 10;
   localparam int SRC_W    = DBL_EW + DBL_MW + 1;
   localparam int HALF_W   = HLF_EW + HLF_MW + 1;
   localparam int DBL_BIAS = (1 << (DBL_EW - 1)) - 1;
   localparam int SGL_BIAS = (1 << (SGL_EW - 1)) - 1;
   localparam int HLF_BIAS = (1 << (HLF_EW - 1)) - 1;
   localparam int EXP_W    = DBL_EW + 2;
   localparam int SUM_W    = EXP_W + HLF_MW;
   localparam int SHL_MAX  = HLF_MW + 2;
   localparam int SHL_W    = $clog2(SHL_MAX + 1);
   localparam int WIDE_W   = HLF_MW + 1 + SHL_MAX + 1;
   localparam int IEEE_TOP = (1 << HLF_EW) - 1;
   localparam int ALT_TOP  = (1 << HLF_EW);

   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_POS     = 2'b01,
      RM_NEG     = 2'b10,
      RM_ZERO    = 2'b11
   } rmode_e;

   typedef enum logic [1:0] {
      CL_ZERO = 2'b00,
      CL_FIN  = 2'b01,
      CL_INF  = 2'b10,
      CL_NAN  = 2'b11
   } vclass_e;

   typedef struct packed {
      logic              sign;
      vclass_e           cls;
      logic [EXP_W-1:0]  exp_rb;
      logic [HLF_MW-1:0] man;
      logic              grd;
      logic              stk;
   } unpacked_t;
endpackage

// File: rtl/fp2h_unpack.sv
module fp2h_unpack
   import fp2h_pkg::*;
(
   input  logic [SRC_W-1:0] src,
   input  logic             is_dbl,
   input  logic             ftz,
   output unpacked_t        u
);
   logic [DBL_EW-1:0] ex;
   logic [DBL_MW-1:0] fr;
   logic              ex_ones;
   logic [EXP_W-1:0]  bias;

   always_comb begin
      if (is_dbl) begin
         u.sign  = src[DBL_EW+DBL_MW];
         ex      = src[DBL_EW+DBL_MW-1:DBL_MW];
         fr      = src[DBL_MW-1:0];
         ex_ones = &src[DBL_EW+DBL_MW-1:DBL_MW];
         bias    = EXP_W'(DBL_BIAS);
      end else begin
         u.sign  = src[SGL_EW+SGL_MW];
         ex      = {{(DBL_EW-SGL_EW){1'b0}}, src[SGL_EW+SGL_MW-1:SGL_MW]};
         fr      = {src[SGL_MW-1:0], {(DBL_MW-SGL_MW){1'b0}}};
         ex_ones = &src[SGL_EW+SGL_MW-1:SGL_MW];
         bias    = EXP_W'(SGL_BIAS);
      end
      // rebias into the half exponent space (two's complement)
      u.exp_rb = {2'b00, ex} - bias + EXP_W'(HLF_BIAS);
      u.man    = fr[DBL_MW-1 -: HLF_MW];
      u.grd    = fr[DBL_MW-HLF_MW-1];
      u.stk    = |fr[DBL_MW-HLF_MW-2:0];
      if (ex_ones)
         u.cls = (fr != '0) ? CL_NAN : CL_INF;
      else if (ex == '0 && (fr == '0 || ftz))
         u.cls = CL_ZERO;
      else
         u.cls = CL_FIN;
   end
endmodule

// File: rtl/fp2h_round.sv
module fp2h_round
   import fp2h_pkg::*;
(
   input  unpacked_t         u,
   input  rmode_e            rm,
   input  logic              dnan,
   input  logic              alt,
   input  logic              uf_trap,
   output logic [HALF_W-1:0] res,
   output logic              f_inv,
   output logic              f_ovf,
   output logic              f_unf,
   output logic              f_inx
);
   localparam logic [HALF_W-2:0] MAX_MAG  = '1;
   localparam logic [HALF_W-2:0] IEEE_INF = {{HLF_EW{1'b1}}, {HLF_MW{1'b0}}};
   localparam logic [HALF_W-2:0] IEEE_BIG = {{(HLF_EW-1){1'b1}}, 1'b0, {HLF_MW{1'b1}}};
   localparam logic [HALF_W-1:0] DEF_QNAN = {1'b0, {HLF_EW{1'b1}}, 1'b1, {(HLF_MW-1){1'b0}}};

   logic                     tiny;
   logic signed [EXP_W-1:0]  one_minus;
   logic [SHL_W-1:0]         sh;
   logic [WIDE_W-1:0]        wide, shv;
   logic [HLF_MW:0]          kept;
   logic                     g, s, inx, up, to_inf;
   logic [EXP_W-1:0]         ebase;
   logic [SUM_W-1:0]         sum;
   logic [EXP_W-1:0]         e_after;
   logic                     over_ieee, over_alt;

   // denormalisation: move the implicit one right, folding lost bits into sticky
   always_comb begin
      tiny      = $signed(u.exp_rb) <= 0;
      one_minus = EXP_W'(1) - $signed(u.exp_rb);
      sh        = (one_minus > EXP_W'(SHL_MAX)) ? SHL_W'(SHL_MAX) : one_minus[SHL_W-1:0];
      wide      = {1'b1, u.man, {(SHL_MAX+1){1'b0}}};
      shv       = wide >> sh;
      if (tiny) begin
         kept  = shv[WIDE_W-1 -: HLF_MW+1];
         g     = shv[SHL_MAX];
         s     = (|shv[SHL_MAX-1:0]) | u.grd | u.stk;
         ebase = '0;
      end else begin
         kept  = {1'b0, u.man};
         g     = u.grd;
         s     = u.stk;
         ebase = u.exp_rb;
      end
      inx = g | s;
      unique case (rm)
         RM_NEAREST: up = g & (s | kept[0]);
         RM_POS:     up = ~u.sign & inx;
         RM_NEG:     up = u.sign & inx;
         default:    up = 1'b0;
      endcase
      sum       = {ebase, {HLF_MW{1'b0}}} + {{(EXP_W-1){1'b0}}, kept} + SUM_W'(up);
      e_after   = sum[SUM_W-1:HLF_MW];
      over_ieee = e_after >= EXP_W'(IEEE_TOP);
      over_alt  = e_after >= EXP_W'(ALT_TOP);
      to_inf    = (rm == RM_NEAREST) || (rm == RM_POS && !u.sign) || (rm == RM_NEG && u.sign);
   end

   always_comb begin
      res   = '0;
      f_inv = 1'b0;
      f_ovf = 1'b0;
      f_unf = 1'b0;
      f_inx = 1'b0;
      unique case (u.cls)
         CL_ZERO: res = {u.sign, {(HALF_W-1){1'b0}}};
         CL_INF: begin
            if (alt) begin
               res   = {u.sign, MAX_MAG};
               f_inv = 1'b1;
            end else begin
               res = {u.sign, IEEE_INF};
            end
         end
         CL_NAN: begin
            f_inv = ~u.man[HLF_MW-1];
            if (alt) begin
               res   = {u.sign, {(HALF_W-1){1'b0}}};
               f_inv = 1'b1;
            end else if (dnan) begin
               res = DEF_QNAN;
            end else begin
               res = {u.sign, {HLF_EW{1'b1}}, 1'b1, u.man[HLF_MW-2:0]};
            end
         end
         default: begin
            if (alt && over_alt) begin
               res   = {u.sign, MAX_MAG};
               f_inv = 1'b1;
            end else if (!alt && over_ieee) begin
               res   = {u.sign, to_inf ? IEEE_INF : IEEE_BIG};
               f_ovf = 1'b1;
               f_inx = 1'b1;
            end else begin
               res   = {u.sign, sum[HALF_W-2:0]};
               f_inx = inx;
               f_unf = tiny & (inx | uf_trap);
            end
         end
      endcase
   end
endmodule

// File: rtl/fp2h_conv.sv
module fp2h_conv
   import fp2h_pkg::*;
#(
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [63:0]       src_bits,
   input  logic              src_is_dbl,
   input  logic [1:0]        rnd_mode,
   input  logic              ftz_en,
   input  logic              dnan_en,
   input  logic              alt_half_en,
   input  logic              uf_trap_en,
   output logic [15:0]       half_out,
   output logic              flag_invalid,
   output logic              flag_overflow,
   output logic              flag_underflow,
   output logic              flag_inexact
);
   localparam int PACK_W = HALF_W + 4;

   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("fp2h_conv: OUT_REG must be 0 or 1");
   end
   if (SRC_W != 64 || HALF_W != 16) begin : g_bad_width
      $error("fp2h_conv: format widths do not match the port widths");
   end

   unpacked_t         u;
   logic [HALF_W-1:0] res_c;
   logic              inv_c, ovf_c, unf_c, inx_c;
   logic [PACK_W-1:0] pack_c, pack_q;

   fp2h_unpack u_unpack (
      .src    (src_bits),
      .is_dbl (src_is_dbl),
      .ftz    (ftz_en),
      .u      (u)
   );

   fp2h_round u_round (
      .u       (u),
      .rm      (rmode_e'(rnd_mode)),
      .dnan    (dnan_en),
      .alt     (alt_half_en),
      .uf_trap (uf_trap_en),
      .res     (res_c),
      .f_inv   (inv_c),
      .f_ovf   (ovf_c),
      .f_unf   (unf_c),
      .f_inx   (inx_c)
   );

   assign pack_c = {inv_c, ovf_c, unf_c, inx_c, res_c};

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pack_q <= '0;
         else        pack_q <= pack_c;
      end
   end else begin : g_comb
      assign pack_q = pack_c;
   end

   assign {flag_invalid, flag_overflow, flag_underflow, flag_inexact, half_out} = pack_q;
endmodule

// File: rtl/fp2h_conv_chk.sv
module fp2h_conv_chk #(
   parameter int OUT_REG = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic [63:0] src_bits,
   input logic        src_is_dbl,
   input logic [1:0]  rnd_mode,
   input logic        ftz_en,
   input logic        dnan_en,
   input logic        alt_half_en,
   input logic        uf_trap_en,
   input logic [15:0] half_out,
   input logic        flag_invalid,
   input logic        flag_overflow,
   input logic        flag_underflow,
   input logic        flag_inexact
);
   logic any_flag;
   logic d_nan, d_zero_exp, d_deep_tiny;
   assign any_flag    = flag_invalid | flag_overflow | flag_underflow | flag_inexact;
   assign d_nan       = src_is_dbl && (&src_bits[62:52]) && (src_bits[51:0] != '0);
   assign d_zero_exp  = src_is_dbl && (src_bits[62:52] == '0);
   assign d_deep_tiny = src_is_dbl && (src_bits[62:52] != '0) && (src_bits[62:52] < 11'd999);

   if (OUT_REG == 1) begin : g_chk
      // R1: outputs still cleared on the first edge after reset release
      a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> (half_out == 16'h0 && !any_flag));
      // R3: single-precision zero of either sign
      a_r3_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n && !src_is_dbl && src_bits[30:0] == '0)
         |-> (half_out == {$past(src_bits[31]), 15'h0} && !any_flag));
      // R5: default NaN
      a_r5_default_nan: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n && d_nan && dnan_en && !alt_half_en) |-> half_out == 16'h7E00);
      // R6: alternative half NaN becomes signed zero
      a_r6_alt_nan: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n && d_nan && alt_half_en)
         |-> (half_out == {$past(src_bits[63]), 15'h0} && flag_invalid));
      // R9: toward zero never overflows to infinity
      a_r9_rz_no_inf: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n && rnd_mode == 2'b11) && flag_overflow) |-> half_out[14:0] == 15'h7BFF);
      // R10: underflow result lies in the subnormal range or the smallest normal
      a_r10_unf_range: assert property (@(posedge clk) disable iff (!rst_n)
         flag_underflow |-> half_out[14:10] <= 5'd1);
      // R10: deep tiny binary64 always reports underflow
      a_r10_deep_tiny: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n && d_deep_tiny && uf_trap_en) |-> flag_underflow);
      // R11: overflow implies inexact and excludes underflow
      a_r11_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
         flag_overflow |-> (flag_inexact && !flag_underflow));
      // R12: alternative half never reports overflow
      a_r12_alt_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n && alt_half_en) |-> !flag_overflow);
      // R13: flushed binary64 subnormal
      a_r13_ftz_zero: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n && ftz_en && d_zero_exp) |-> (half_out[14:0] == '0 && !any_flag));
   end
endmodule

bind fp2h_conv fp2h_conv_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .src_bits       (src_bits),
   .src_is_dbl     (src_is_dbl),
   .rnd_mode       (rnd_mode),
   .ftz_en         (ftz_en),
   .dnan_en        (dnan_en),
   .alt_half_en    (alt_half_en),
   .uf_trap_en     (uf_trap_en),
   .half_out       (half_out),
   .flag_invalid   (flag_invalid),
   .flag_overflow  (flag_overflow),
   .flag_underflow (flag_underflow),
   .flag_inexact   (flag_inexact)
);

// File: tb/fp2h_conv_tb.sv
`timescale 1ns/1ps
module fp2h_conv_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src_bits = '0;
   logic        src_is_dbl = 1'b0;
   logic [1:0]  rnd_mode = 2'b00;
   logic        ftz_en = 1'b0, dnan_en = 1'b0, alt_half_en = 1'b0, uf_trap_en = 1'b0;
   logic [15:0] half_out;
   logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

   int  vectors = 0;
   int  miscompares = 0;
   bit  done = 0;

   always #10 clk = ~clk;

   fp2h_conv dut_i (
      .clk(clk), .rst_n(rst_n), .src_bits(src_bits), .src_is_dbl(src_is_dbl),
      .rnd_mode(rnd_mode), .ftz_en(ftz_en), .dnan_en(dnan_en),
      .alt_half_en(alt_half_en), .uf_trap_en(uf_trap_en), .half_out(half_out),
      .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
      .flag_underflow(flag_underflow), .flag_inexact(flag_inexact)
   );

   // expected {invalid, overflow, underflow, inexact, half}
   function automatic logic [19:0] ref_conv(logic [63:0] x, logic dbl, logic [1:0] rm,
                                            logic ftz, logic dn, logic alt, logic uft);
      logic sg;
      int e, emax, bias, mant, v;
      logic [51:0] fr;
      bit top, rest0, tiny, inx, up, inv;
      logic [15:0] h;
      if (dbl) begin
         sg = x[63]; e = int'(x[62:52]); fr = x[51:0]; emax = 2047; bias = 1023;
      end else begin
         sg = x[31]; e = int'(x[30:23]); fr = {x[22:0], 29'd0}; emax = 255; bias = 127;
      end
      if (e == emax) begin
         inv = 0;
         if (fr != 0) begin
            inv = (fr[51] == 1'b0);
            if (alt) begin h = {sg, 15'h0}; inv = 1; end
            else if (dn) h = 16'h7E00;
            else h = {sg, 5'h1F, fr[51:42] | 10'h200};
         end else if (alt) begin h = {sg, 15'h7FFF}; inv = 1; end
         else h = {sg, 15'h7C00};
         return {inv, 3'b000, h};
      end
      if (e == 0 && (fr == 0 || ftz)) return {4'b0000, sg, 15'h0};
      e = e - bias + 15;
      mant = int'(fr[51:42]);
      top = fr[41];
      rest0 = (fr[40:0] == 0);
      tiny = 0;
      if (e <= 0) begin
         tiny = 1;
         mant = mant + 1024;
         while (e <= 0) begin
            rest0 = rest0 && !top;
            top = (mant % 2) == 1;
            mant = mant / 2;
            e = e + 1;
         end
         e = 0;
      end
      inx = top || !rest0;
      case (rm)
         2'b00: up = top && (!rest0 || (mant % 2) == 1);
         2'b01: up = !sg && inx;
         2'b10: up = sg && inx;
         default: up = 0;
      endcase
      v = e * 1024 + mant + (up ? 1 : 0);
      if (alt && v >= 32 * 1024) return {4'b1000, sg, 15'h7FFF};
      if (!alt && v >= 31 * 1024) begin
         h = ((rm == 2'b00) || (rm == 2'b01 && !sg) || (rm == 2'b10 && sg))
             ? {sg, 15'h7C00} : {sg, 15'h7BFF};
         return {4'b0101, h};
      end
      return {2'b00, tiny && (inx || uft), inx, sg, v[14:0]};
   endfunction

   function automatic logic [63:0] mk(logic dbl, logic sg, int ex_unb, logic [51:0] fr,
                                      logic [31:0] junk);
      if (dbl) return {sg, 11'(ex_unb + 1023), fr};
      return {junk, sg, 8'(ex_unb + 127), fr[51:29]};
   endfunction

   task automatic apply(string tag, logic [63:0] x, logic dbl, logic [1:0] rm,
                        logic ftz, logic dn, logic alt, logic uft);
      logic [19:0] exp_v, act_v;
      @(negedge clk);
      src_bits = x; src_is_dbl = dbl; rnd_mode = rm;
      ftz_en = ftz; dnan_en = dn; alt_half_en = alt; uf_trap_en = uft;
      exp_v = ref_conv(x, dbl, rm, ftz, dn, alt, uft);
      @(negedge clk);
      act_v = {flag_invalid, flag_overflow, flag_underflow, flag_inexact, half_out};
      vectors++;
      if (act_v !== exp_v) begin
         miscompares++;
         $display("FAIL %s src=%h dbl=%0b rm=%0d ftz=%0b dn=%0b alt=%0b uft=%0b actual=%h expected=%h",
                  tag, x, dbl, rm, ftz, dn, alt, uft, act_v, exp_v);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state
      src_bits = 64'h3FF0_0000_0000_0000; src_is_dbl = 1'b1;
      repeat (3) @(negedge clk);
      vectors++;
      if ({flag_invalid, flag_overflow, flag_underflow, flag_inexact, half_out} !== 20'h0) begin
         miscompares++;
         $display("FAIL R1 reset actual=%h expected=%h",
                  {flag_invalid, flag_overflow, flag_underflow, flag_inexact, half_out}, 20'h0);
      end
      @(negedge clk) rst_n = 1'b1;

      // directed corner cases
      apply("R1 R2 one dbl",        64'h3FF0_0000_0000_0000, 1, 0, 0, 0, 0, 0);
      apply("R2 one sgl junk hi",   64'hDEAD_BEEF_3F80_0000, 0, 0, 0, 0, 0, 0);
      apply("R3 neg zero",          64'h8000_0000_0000_0000, 1, 0, 0, 0, 0, 0);
      apply("R3 zero sgl",          64'hFFFF_FFFF_0000_0000, 0, 0, 0, 0, 0, 0);
      apply("R4 snan quieted",      64'h7FF0_0000_0000_0001, 1, 0, 0, 0, 0, 0);
      apply("R4 qnan payload",      64'hFFFA_0000_0000_0000, 1, 0, 0, 0, 0, 0);
      apply("R5 default nan s",     64'h7FF0_0000_0000_0001, 1, 0, 0, 1, 0, 0);
      apply("R5 default nan q sgl", 64'h0000_0000_FFC0_0001, 0, 0, 0, 1, 0, 0);
      apply("R6 alt nan",           64'hFFF8_0000_0000_0000, 1, 0, 0, 0, 1, 0);
      apply("R6 alt inf",           64'h7FF0_0000_0000_0000, 1, 0, 0, 0, 1, 0);
      apply("R7 ieee inf",          64'hFFF0_0000_0000_0000, 1, 0, 0, 0, 0, 0);
      apply("R8 tie even down",     64'h3FF0_0200_0000_0000, 1, 0, 0, 0, 0, 0);
      apply("R8 tie odd up",        64'h3FF0_0600_0000_0000, 1, 0, 0, 0, 0, 0);
      apply("R8 carry to exp",      64'h3FFF_FFFF_FFFF_FFFF, 1, 0, 0, 0, 0, 0);
      apply("R9 toward pos",        64'h3FF0_0000_0000_0001, 1, 1, 0, 0, 0, 0);
      apply("R9 toward neg pos",    64'h3FF0_0000_0000_0001, 1, 2, 0, 0, 0, 0);
      apply("R9 toward neg neg",    64'hBFF0_0000_0000_0001, 1, 2, 0, 0, 0, 0);
      apply("R9 toward zero",       64'hBFF0_03FF_FFFF_FFFF, 1, 3, 0, 0, 0, 0);
      apply("R10 min sub exact",    64'h3E70_0000_0000_0000, 1, 0, 0, 0, 0, 0);
      apply("R10 min sub trap",     64'h3E70_0000_0000_0000, 1, 0, 0, 0, 0, 1);
      apply("R10 half min tie",     64'h3E60_0000_0000_0000, 1, 0, 0, 0, 0, 0);
      apply("R10 sub rounds normal",64'h3F0F_FFFF_FFFF_FFFF, 1, 0, 0, 0, 0, 0);
      apply("R11 ovf nearest",      64'h40F0_0000_0000_0000, 1, 0, 0, 0, 0, 0);
      apply("R11 ovf zero",         64'h40F0_0000_0000_0000, 1, 3, 0, 0, 0, 0);
      apply("R11 ovf neg pos",      64'hC0F0_0000_0000_0000, 1, 1, 0, 0, 0, 0);
      apply("R11 round into ovf",   64'h40EF_FFFF_FFFF_FFFF, 1, 0, 0, 0, 0, 0);
      apply("R12 alt exp31",        64'h40F0_0000_0000_0000, 1, 0, 0, 0, 1, 0);
      apply("R12 alt ovf",          64'hC100_0000_0000_0000, 1, 0, 0, 0, 1, 0);
      apply("R13 ftz dbl sub",      64'h8000_0000_0000_0001, 1, 1, 1, 0, 0, 0);
      apply("R13 ftz sgl sub",      64'h0000_0000_0000_0001, 0, 2, 1, 0, 0, 0);
      apply("R14 sub no ftz",       64'h0000_0000_0000_0001, 1, 1, 0, 0, 0, 0);
      apply("R14 inexact sgl",      64'h0000_0000_3F80_0001, 0, 0, 0, 0, 0, 0);

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic        dbl, sg;
         logic [51:0] fr;
         logic [63:0] x;
         int          sel, ex;
         dbl = 1'($urandom);
         sg  = 1'($urandom);
         fr  = {20'($urandom), 32'($urandom)};
         if ($urandom % 4 == 0) fr[41:0] = '0;
         sel = int'($urandom % 16);
         x   = mk(dbl, sg, int'($urandom % 48) - 30, fr, $urandom);
         if (sel == 0) begin
            if (dbl) x[62:52] = '0; else x[30:23] = '0;
         end else if (sel == 1) begin
            if (dbl) x[62:52] = '1; else x[30:23] = '1;
         end else if (sel == 2) begin
            ex = dbl ? int'($urandom % 2046) - 1022 : int'($urandom % 254) - 126;
            x  = mk(dbl, sg, ex, fr, $urandom);
         end
         apply("R2 R8 R9 R10 R14 random", x, dbl, 2'($urandom),
               ($urandom % 4) == 0, ($urandom % 4) == 0,
               ($urandom % 4) == 0, ($urandom % 4) == 0);
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule